// File: doc/BRIEF.md
# 32-bit Registered ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a small RISC core. Each cycle in which `in_valid` is high, it takes a 4-bit operation code, a destination operand A and a source or immediate operand B. On the next clock edge it presents a 32-bit result, a register write-enable and a 4-bit condition-flag word.

The operations are add, subtract, compare, AND, OR, test, three shifts, rotate left, two half-word loads and two 16x16 multiplies. Compare and test update only the flags. The shifts raise overflow whenever the sign bit changes, and shift counts saturate at 32. The multiplies use the low half of each operand. Register file, decode, branching and memory access live elsewhere.

The flag word is a condition-code register. It keeps its value until a defined operation is issued.

Top module: `flag_alu`

## Requirements
- R1: Reset clears `out_valid`, `out_wr`, `out_res` and `out_flags`. An operation issued with `in_valid` high in cycle t appears on the outputs after the clock edge ending cycle t, with `out_valid` high for exactly that one cycle.
- R2: The flag word holds zero in bit 0, carry in bit 1, negative in bit 2 and overflow in bit 3. ADD (code 0) writes A+B. Carry is the carry out of bit 31. Overflow is set when the signed sum leaves the 32-bit range (so 0x7FFFFFFF+1 gives flags 0xC, and 0xFFFFFFFF+1 gives flags 0x3).
- R3: SUB (code 1) writes A−B. Carry is set as a borrow when B > A unsigned. Overflow is set on signed range exit. CMP (code 2) computes the same result and flags with `out_wr` low.
- R4: AND (code 3) and OR (code 4) write the bitwise result. TST (code 5) computes A AND B with `out_wr` low. All three clear carry and overflow.
- R5: For every defined operation, zero is set exactly when the 32-bit result is 0, and negative equals result bit 31.
- R6: LSR (code 6), ASR (code 7) and LSL (code 8) take the count from B[5:0]. Counts above 32 act as 32. Count 0 leaves A unchanged and clears carry. Otherwise carry is the last bit shifted out (LSR by 32 of all-ones gives 0, ASR by 32 of all-ones gives all-ones).
- R7: For the three shifts, overflow is set exactly when result bit 31 differs from A bit 31.
- R8: ROL (code 9) rotates A left by B[4:0] and clears carry and overflow.
- R9: LDHI (code 10) writes {B[15:0], A[15:0]}. LDLO (code 11) writes {A[31:16], B[15:0]}. Both clear carry and overflow.
- R10: MPYU (code 12) writes the unsigned product of A[15:0] and B[15:0] (0xFFFF×0xFFFF = 0xFFFE0001) and clears carry and overflow.
- R11: MPYS (code 13) writes the two's-complement product of A[15:0] and B[15:0] (0x8001×0x7FFF = 0xC000FFFF, 0x8000×0x8000 = 0x40000000) and clears carry and overflow.
- R12: In a cycle after one with `in_valid` low, `out_valid` and `out_wr` are low, and `out_res` and `out_flags` keep their values.
- R13: Codes 14 and 15 give `out_valid` high, `out_wr` low, and leave `out_res` and `out_flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Destination operand |
| in_b | input | 32 | Source operand or immediate |
| out_valid | output | 1 | Result present this cycle |
| out_wr | output | 1 | Result is to be written back |
| out_res | output | 32 | Result |
| out_flags | output | 4 | Condition flags {V,N,C,Z} |

## Verification
Every result, write-enable and flag update is due exactly one clock edge after the cycle in which its operation was issued. Nothing in the block takes longer. The driver applies each operation just after a falling edge and queues the expected item. The monitor samples at the following falling edge, when `out_valid` should be high, and compares against the head of the queue, so each comparison lands on the one cycle the result is due. In idle cycles the monitor checks that result and flags held the last values seen.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int XLEN  = 32;
    localparam int HLEN  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN) + 1;
    localparam int OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_TST  = 4'd5,
        OP_LSR  = 4'd6,
        OP_ASR  = 4'd7,
        OP_LSL  = 4'd8,
        OP_ROL  = 4'd9,
        OP_LDHI = 4'd10,
        OP_LDLO = 4'd11,
        OP_MPYU = 4'd12,
        OP_MPYS = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSR = 2'd0,
        SH_ASR = 2'd1,
        SH_LSL = 2'd2
    } shift_kind_e;

    // bit 0 = zero, bit 1 = carry, bit 2 = negative, bit 3 = overflow
    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } alu_flags_t;

    function automatic logic [CNT_W-1:0] sat_count(input logic [CNT_W-1:0] raw);
        return (raw > CNT_W'(XLEN)) ? CNT_W'(XLEN) : raw;
    endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] res,
    output logic            carry,
    output logic            ovf
);
    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   sum;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
        res   = sum[XLEN-1:0];
        // On subtraction carry-out high means no borrow.
        carry = sub ? ~sum[XLEN] : sum[XLEN];
        ovf   = (a[XLEN-1] == b_eff[XLEN-1]) && (res[XLEN-1] != a[XLEN-1]);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
(
    input  logic [XLEN-1:0]  a,
    input  logic [CNT_W-1:0] cnt,
    input  shift_kind_e      kind,
    output logic [XLEN-1:0]  res,
    output logic             carry
);
    logic [CNT_W-1:0]        n;
    logic signed [XLEN+1:0]  rt_in;
    logic [XLEN+1:0]         rt_out;
    logic [XLEN:0]           lf_out;

    always_comb begin
        n = sat_count(cnt);
        // Right shifts: a guard bit below A catches the last bit shifted out.
        rt_in  = {(kind == SH_ASR) & a[XLEN-1], a, 1'b0};
        rt_out = rt_in >>> n;
        // Left shift: an extra bit above A catches the last bit shifted out.
        lf_out = {1'b0, a} << n;
        if (kind == SH_LSL) begin
            res   = lf_out[XLEN-1:0];
            carry = lf_out[XLEN];
        end else begin
            res   = rt_out[XLEN:1];
            carry = rt_out[0];
        end
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul
    import alu_pkg::*;
(
    input  logic [HLEN-1:0] a,
    input  logic [HLEN-1:0] b,
    input  logic            sgn,
    output logic [XLEN-1:0] res
);
    logic signed [HLEN:0]   a_x;
    logic signed [HLEN:0]   b_x;
    logic signed [2*HLEN+1:0] prod;

    always_comb begin
        a_x  = {sgn & a[HLEN-1], a};
        b_x  = {sgn & b[HLEN-1], b};
        prod = a_x * b_x;
        res  = prod[XLEN-1:0];
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [3:0]      in_op,
    input  logic [31:0]     in_a,
    input  logic [31:0]     in_b,
    output logic            out_valid,
    output logic            out_wr,
    output logic [31:0]     out_res,
    output logic [3:0]      out_flags
);
    logic [XLEN-1:0] as_res, sh_res, mul_res;
    logic            as_c, as_v, sh_c;
    shift_kind_e     sh_kind;

    logic [XLEN-1:0] nx_res;
    alu_flags_t      nx_flags, flags_q;
    logic            nx_wr, nx_known;

    always_comb begin
        unique case (in_op)
            OP_ASR:  sh_kind = SH_ASR;
            OP_LSL:  sh_kind = SH_LSL;
            default: sh_kind = SH_LSR;
        endcase
    end

    alu_addsub u_addsub (
        .a     (in_a),
        .b     (in_b),
        .sub   (in_op != OP_ADD),
        .res   (as_res),
        .carry (as_c),
        .ovf   (as_v)
    );

    alu_shift u_shift (
        .a     (in_a),
        .cnt   (in_b[CNT_W-1:0]),
        .kind  (sh_kind),
        .res   (sh_res),
        .carry (sh_c)
    );

    alu_mul u_mul (
        .a   (in_a[HLEN-1:0]),
        .b   (in_b[HLEN-1:0]),
        .sgn (in_op == OP_MPYS),
        .res (mul_res)
    );

    always_comb begin
        nx_res   = '0;
        nx_flags = '0;
        nx_wr    = 1'b1;
        nx_known = 1'b1;
        unique case (in_op)
            OP_ADD, OP_SUB, OP_CMP: begin
                nx_res     = as_res;
                nx_flags.c = as_c;
                nx_flags.v = as_v;
                nx_wr      = (in_op != OP_CMP);
            end
            OP_AND, OP_TST: begin
                nx_res = in_a & in_b;
                nx_wr  = (in_op == OP_AND);
            end
            OP_OR:   nx_res = in_a | in_b;
            OP_LSR, OP_ASR, OP_LSL: begin
                nx_res     = sh_res;
                nx_flags.c = sh_c;
                nx_flags.v = sh_res[XLEN-1] ^ in_a[XLEN-1];
            end
            OP_ROL:  nx_res = (in_a << in_b[CNT_W-2:0])
                            | (in_a >> (CNT_W-1)'(XLEN - int'(in_b[CNT_W-2:0])));
            OP_LDHI: nx_res = {in_b[HLEN-1:0], in_a[HLEN-1:0]};
            OP_LDLO: nx_res = {in_a[XLEN-1:HLEN], in_b[HLEN-1:0]};
            OP_MPYU, OP_MPYS: nx_res = mul_res;
            default: begin
                nx_wr    = 1'b0;
                nx_known = 1'b0;
            end
        endcase
        nx_flags.z = (nx_res == '0);
        nx_flags.n = nx_res[XLEN-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_wr    <= 1'b0;
            out_res   <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr    <= in_valid & nx_wr;
            if (in_valid && nx_known) begin
                out_res <= nx_res;
                flags_q <= nx_flags;
            end
        end
    end

    assign out_flags = flags_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  in_op,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic        out_valid,
    input logic        out_wr,
    input logic [31:0] out_res,
    input logic [3:0]  out_flags
);
    // R1
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R12
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wr && $stable(out_res) && $stable(out_flags)));
    // R2
    p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd0) |=> (out_res == $past(in_a) + $past(in_b)));
    // R3
    p_cmp_nowr_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd2) |=> (!out_wr && out_flags[0] == ($past(in_a) == $past(in_b))));
    // R4
    p_logic_cv_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == 4'd3 || in_op == 4'd4 || in_op == 4'd5)) |=> (out_flags[3] == 1'b0 && out_flags[1] == 1'b0));
    // R5
    p_zn_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op <= 4'd13) |=> (out_flags[0] == (out_res == 32'd0) && out_flags[2] == out_res[31]));
    // R7
    p_shift_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 4'd6 && in_op <= 4'd8) |=> (out_flags[3] == (out_res[31] != $past(in_a[31]))));
    // R13
    p_undef_keep_r13: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 4'd14) |=> (!out_wr && $stable(out_flags) && $stable(out_res)));
endmodule

bind flag_alu flag_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_wr    (out_wr),
    .out_res   (out_res),
    .out_flags (out_flags)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [31:0] res;
        logic [3:0]  flags;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid, out_wr;
    logic [31:0] out_res;
    logic [3:0]  out_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] m_res = '0;
    logic [3:0]  m_flags = '0;
    logic [31:0] seen_res = '0;
    logic [3:0]  seen_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_wr(out_wr),
        .out_res(out_res), .out_flags(out_flags)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        logic c, v;
        logic [31:0] r;
        longint s;
        int n;
        c = 0; v = 0; r = 0;
        e.wr = 1'b1;
        n = (b[5:0] > 32) ? 32 : int'(b[5:0]);
        case (op)
            4'd0: begin
                s = longint'($signed(a)) + longint'($signed(b));
                r = a + b;
                c = ({32'd0, a} + {32'd0, b}) > 64'hFFFFFFFF;
                v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            4'd1, 4'd2: begin
                s = longint'($signed(a)) - longint'($signed(b));
                r = a - b;
                c = b > a;
                v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                e.wr = (op == 4'd1);
            end
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: begin r = a & b; e.wr = 1'b0; end
            4'd6, 4'd7, 4'd8: begin
                r = a;
                for (int i = 0; i < n; i++) begin
                    if (op == 4'd8) begin c = r[31]; r = {r[30:0], 1'b0}; end
                    else begin c = r[0]; r = {(op == 4'd7) & r[31], r[31:1]}; end
                end
                v = r[31] != a[31];
            end
            4'd9: begin
                r = a;
                for (int i = 0; i < int'(b[4:0]); i++) r = {r[30:0], r[31]};
            end
            4'd10: r = {b[15:0], a[15:0]};
            4'd11: r = {a[31:16], b[15:0]};
            4'd12: r = 32'(longint'(a[15:0]) * longint'(b[15:0]));
            4'd13: r = 32'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])));
            default: begin
                e.wr = 1'b0;
                e.res = m_res;
                e.flags = m_flags;
                return e;
            end
        endcase
        e.res = r;
        e.flags = {v, r[31], c, (r == 0)};
        return e;
    endfunction

    task automatic send(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        e = model(op, a, b);
        m_res = e.res; m_flags = e.flags;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = 32'hA5A5A5A5; in_b = 32'h5A5A5A5A; in_op = 4'd0;
        end
    endtask

    // Monitor: results are due one edge after issue, sampled at the next falling edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {out_wr, out_res, out_flags}, {e.wr, e.res, e.flags});
                end
            end else begin
                check("R12 idle hold", {out_wr, out_res, out_flags}, {1'b0, seen_res, seen_flags});
            end
            seen_res = out_res;
            seen_flags = out_flags;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset state", {out_valid, out_wr, out_res, out_flags}, 38'd0);

        send("R2 add overflow",       4'd0, 32'h7FFFFFFF, 32'd1);
        send("R2 add carry",          4'd0, 32'hFFFFFFFF, 32'd1);
        send("R3 sub overflow",       4'd1, 32'h80000000, 32'd1);
        send("R3 sub borrow",         4'd1, 32'd0, 32'd1);
        idle(1);
        send("R3 cmp equal",          4'd2, 32'd5, 32'd5);
        send("R4 and",                4'd3, 32'hF0F0FF00, 32'hFF00F0F0);
        send("R4 or",                 4'd4, 32'h00000074, 32'h00003500);
        send("R4 tst zero",           4'd5, 32'h0000F000, 32'h00000F00);
        send("R5 zero negative",      4'd1, 32'd3, 32'd3);
        send("R6 lsr 32 all ones",    4'd6, 32'hFFFFFFFF, 32'd32);
        send("R6 lsr 0 clears carry", 4'd6, 32'hFFFFFFFF, 32'd0);
        send("R6 lsr 1 carry",        4'd6, 32'hFFFFFFFF, 32'd1);
        send("R6 asr 32 all ones",    4'd7, 32'hFFFFFFFF, 32'd32);
        send("R6 asr 45 saturates",   4'd7, 32'h80000001, 32'd45);
        send("R6 lsl 8",              4'd8, 32'h00000035, 32'd8);
        send("R6 lsl 63 saturates",   4'd8, 32'h00000001, 32'h0000007F);
        send("R7 lsr sign change",    4'd6, 32'h80000000, 32'd1);
        send("R7 lsl pos to neg",     4'd8, 32'h40000000, 32'd1);
        send("R7 lsl neg to pos",     4'd8, 32'h80000000, 32'd1);
        send("R8 rol",                4'd9, 32'h80000001, 32'd4);
        send("R8 rol uses low 5 bits",4'd9, 32'h12345678, 32'd36);
        send("R9 ldhi",               4'd10, 32'h00001234, 32'h0000DEAD);
        send("R9 ldlo",               4'd11, 32'hDEAD1234, 32'hFFFFBEEF);
        send("R10 mpyu ffff",         4'd12, 32'hABCDFFFF, 32'h1234FFFF);
        send("R10 mpyu 23171",        4'd12, 32'd23171, 32'd23171);
        send("R11 mpys neg",          4'd13, 32'h00008001, 32'h00007FFF);
        send("R11 mpys min",          4'd13, 32'h00008000, 32'hFFFF8000);
        idle(2);
        send("R13 undefined 14",      4'd14, 32'h1, 32'h2);
        send("R13 undefined 15",      4'd15, 32'h0, 32'h0);
        idle(3);
        send("R2 add plain",          4'd0, 32'd20, 32'd22);
        idle(3);
        done = 1'b1;
        check("R1 queue drained", 64'(exp_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule